// File: doc/BRIEF.md
# Upstream Reset and PLL Sequencer

This block runs in the upstream clock domain of a bus bridge. It watches the active-low upstream bus reset. When that reset lets go, it takes a snapshot of the initialization pattern on the bus, which is a mode bit and a frequency range code. From that snapshot it decides how to bring the domain out of reset.

In the high-speed mode the sequencer presents the PLL range and tuning bits and releases the PLL reset. It then keeps the domain's logic reset asserted for a lock allowance, given in clock cycles as a parameter. In the legacy mode the PLL reset stays asserted so the PLL remains bypassed, and the logic reset is stretched by a short fixed number of cycles.

A separate output tells the transaction logic not to respond on the upstream bus while the logic reset is active. Pulling the upstream reset low again at any point returns the block to its reset state.

Top module: `upstream_rst_seq`

## Requirements
- R1: In any clock edge that samples `bus_rst_n` low, the following outputs take these values: `pll_rst`=1, `logic_rst`=1, `bus_block`=1, `pll_range`=0 and `pll_tune`=0.
- R2: The mode bit and range code are captured only at the first clock edge that samples `bus_rst_n` high after a reset. Later changes on `init_mode` or `init_range` have no effect on any output until the next reset.
- R3: High-speed mode is `init_mode`=1. At the capture edge, `pll_rst` falls to 0, `pll_range` takes the captured code, and `pll_tune` becomes one-hot with bit number equal to the code.
- R4: In high-speed mode, `logic_rst` stays 1 for exactly `LOCK_CYCLES` edges after the capture edge and falls at capture edge + `LOCK_CYCLES`.
- R5: Legacy mode is `init_mode`=0. In this mode `pll_rst` stays 1, and `pll_range` and `pll_tune` stay 0.
- R6: In legacy mode, `logic_rst` falls at capture edge + `LEGACY_EXTRA`, which defaults to 7.
- R7: `bus_block` equals `logic_rst` on every cycle.
- R8: Reasserting `bus_rst_n` during or after a sequence restores the R1 state at the next edge. The following release starts a fresh capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Upstream domain clock |
| bus_rst_n | input | 1 | Upstream bus reset, active low, sampled synchronously |
| init_mode | input | 1 | Pattern mode bit: 1 high-speed, 0 legacy |
| init_range | input | RANGE_W | Pattern frequency range code |
| pll_rst | output | 1 | PLL reset, 1 keeps the PLL in bypass |
| pll_range | output | RANGE_W | PLL range select |
| pll_tune | output | 2**RANGE_W | PLL tuning select, one-hot |
| logic_rst | output | 1 | Logic reset for the upstream domain |
| bus_block | output | 1 | Blocks responses to upstream transactions |

## Verification
Some properties are checked by assertions on every cycle:
- the reset state after a sampled low reset;
- that the captured range and tuning do not change outside the capture edge;
- that tuning is one-hot whenever the PLL runs;
- that the PLL stays in bypass during legacy sequences;
- that the block output tracks the logic reset;
- that the timer expires only once.

The exact edge at which the logic reset falls in each mode, and the behaviour when reset is reasserted part way through a hold, can only be shown by the bench's timed scenarios. Those scenarios mix random patterns with directed aborts.

// File: rtl/ursq_pkg.sv
package ursq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_HOLD = 2'd1,
    SQ_RUN  = 2'd2
  } sq_state_t;
endpackage

// File: rtl/ursq_capture.sv
// Captures the range code at the release edge and decodes the tuning select.
module ursq_capture #(
  parameter int RANGE_W = 2,
  localparam int TUNE_W = 1 << RANGE_W
) (
  input  logic               clk,
  input  logic               bus_rst_n,
  input  logic               load,
  input  logic               pat_mode,
  input  logic [RANGE_W-1:0] pat_range,
  output logic               mode_q,
  output logic [RANGE_W-1:0] range_q,
  output logic [TUNE_W-1:0]  tune_q
);
  logic [TUNE_W-1:0] tune_dec;

  for (genvar g = 0; g < TUNE_W; g++) begin : g_tune
    assign tune_dec[g] = (pat_range == RANGE_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!bus_rst_n) begin
      mode_q  <= 1'b0;
      range_q <= '0;
      tune_q  <= '0;
    end else if (load) begin
      mode_q  <= pat_mode;
      range_q <= pat_mode ? pat_range : '0;
      tune_q  <= pat_mode ? tune_dec : '0;
    end
  end

  // R2: snapshot holds between captures
  assert_snapshot_held_R2: assert property (@(posedge clk) disable iff (!bus_rst_n)
    !load |=> ($stable(range_q) && $stable(tune_q) && $stable(mode_q)));
endmodule

// File: rtl/ursq_timer.sv
// Down-counter that flags expiry once after being loaded.
module ursq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             kill,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic             active_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (kill) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (load) begin
      active_q <= 1'b1;
      cnt_q    <= load_val;
    end else if (active_q) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - 1'b1;
    end
  end

  assign expired = active_q && (cnt_q == '0);

  // R4: one expiry per load, never repeated
  assert_single_expiry_R4: assert property (@(posedge clk) disable iff (kill)
    (expired && !load) |=> !expired);
endmodule

// File: rtl/upstream_rst_seq.sv
module upstream_rst_seq #(
  parameter int RANGE_W      = 2,
  parameter int LOCK_CYCLES  = 12500,
  parameter int LEGACY_EXTRA = 7,
  localparam int TUNE_W  = 1 << RANGE_W,
  localparam int MAX_CYC = (LOCK_CYCLES > LEGACY_EXTRA) ? LOCK_CYCLES : LEGACY_EXTRA,
  localparam int CNT_W   = $clog2(MAX_CYC + 1)
) (
  input  logic               clk,
  input  logic               bus_rst_n,
  input  logic               init_mode,
  input  logic [RANGE_W-1:0] init_range,
  output logic               pll_rst,
  output logic [RANGE_W-1:0] pll_range,
  output logic [TUNE_W-1:0]  pll_tune,
  output logic               logic_rst,
  output logic               bus_block
);
  import ursq_pkg::*;

  localparam logic [CNT_W-1:0] LOCK_LD = CNT_W'(LOCK_CYCLES - 1);
  localparam logic [CNT_W-1:0] LEG_LD  = CNT_W'(LEGACY_EXTRA - 1);

  sq_state_t        state_q;
  logic             capture;
  logic             mode_q;
  logic             tmr_expired;
  logic [CNT_W-1:0] hold_ld;

  assign capture = bus_rst_n && (state_q == SQ_IDLE);
  assign hold_ld = init_mode ? LOCK_LD : LEG_LD;

  ursq_capture #(.RANGE_W(RANGE_W)) i_capture (
    .clk       (clk),
    .bus_rst_n (bus_rst_n),
    .load      (capture),
    .pat_mode  (init_mode),
    .pat_range (init_range),
    .mode_q    (mode_q),
    .range_q   (pll_range),
    .tune_q    (pll_tune)
  );

  ursq_timer #(.CNT_W(CNT_W)) i_timer (
    .clk      (clk),
    .kill     (!bus_rst_n),
    .load     (capture),
    .load_val (hold_ld),
    .expired  (tmr_expired)
  );

  always_ff @(posedge clk) begin
    if (!bus_rst_n) begin
      state_q   <= SQ_IDLE;
      pll_rst   <= 1'b1;
      logic_rst <= 1'b1;
      bus_block <= 1'b1;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          pll_rst <= !init_mode;
          state_q <= SQ_HOLD;
        end
        SQ_HOLD: begin
          if (tmr_expired) begin
            logic_rst <= 1'b0;
            bus_block <= 1'b0;
            state_q   <= SQ_RUN;
          end
        end
        default: ;
      endcase
    end
  end

  // R1: reset state visible after any sampled low reset
  logic seen_low_q;
  always_ff @(posedge clk) seen_low_q <= !bus_rst_n;
  always @(posedge clk) begin
    if (seen_low_q) begin
      assert_reset_hold_R1: assert (pll_rst && logic_rst && bus_block &&
                                    pll_range == '0 && pll_tune == '0);
    end
  end

  // R3: running PLL always sees a one-hot tuning select
  assert_tune_onehot_R3: assert property (@(posedge clk) disable iff (!bus_rst_n)
    !pll_rst |-> ($countones(pll_tune) == 1));

  // R5: legacy capture keeps the PLL bypassed
  assert_legacy_bypass_R5: assert property (@(posedge clk) disable iff (!bus_rst_n)
    (state_q != SQ_IDLE && !mode_q) |-> pll_rst);

  // R7: response block follows the logic reset
  assert_block_tracks_R7: assert property (@(posedge clk) disable iff (!bus_rst_n)
    bus_block == logic_rst);
endmodule

// File: tb/test_upstream_rst_seq.sv
module test_upstream_rst_seq;
  localparam int RW   = 2;
  localparam int TW   = 1 << RW;
  localparam int LOCK = 40;
  localparam int LEG  = 7;

  logic          clk = 1'b0;
  logic          bus_rst_n = 1'b0;
  logic          init_mode = 1'b0;
  logic [RW-1:0] init_range = '0;
  logic          pll_rst, logic_rst, bus_block;
  logic [RW-1:0] pll_range;
  logic [TW-1:0] pll_tune;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  upstream_rst_seq #(.RANGE_W(RW), .LOCK_CYCLES(LOCK), .LEGACY_EXTRA(LEG)) i_upstream_rst_seq (
    .clk(clk), .bus_rst_n(bus_rst_n), .init_mode(init_mode), .init_range(init_range),
    .pll_rst(pll_rst), .pll_range(pll_range), .pll_tune(pll_tune),
    .logic_rst(logic_rst), .bus_block(bus_block)
  );

  function automatic int exp_hold(bit m);
    return m ? LOCK : LEG;
  endfunction

  function automatic int exp_tune(bit m, int r);
    return m ? (1 << r) : 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_reset_state(string req);
    chk({req, " pll_rst"}, pll_rst, 1);
    chk({req, " logic_rst"}, logic_rst, 1);
    chk({req, " bus_block"}, bus_block, 1);
    chk({req, " pll_range"}, pll_range, 0);
    chk({req, " pll_tune"}, pll_tune, 0);
  endtask

  task automatic do_reset(int cyc);
    @(negedge clk);
    bus_rst_n = 1'b0;
    repeat (cyc) @(negedge clk);
    chk_reset_state("R1");
  endtask

  // abort_at < 0 runs to completion; otherwise reset is reasserted at step abort_at
  task automatic run_seq(bit m, int r, int abort_at);
    int hold;
    hold = exp_hold(m);
    @(negedge clk);
    bus_rst_n  = 1'b1;
    init_mode  = m;
    init_range = RW'(r);
    @(negedge clk);
    for (int j = 0; j <= hold + 2; j++) begin
      if (j == abort_at) begin
        bus_rst_n = 1'b0;
        @(negedge clk);
        chk_reset_state("R8");
        return;
      end
      if (m) begin
        chk("R3 pll_rst", pll_rst, 0);
        chk("R3 pll_range", pll_range, r);
        chk("R3 pll_tune", pll_tune, exp_tune(m, r));
        chk("R4 logic_rst", logic_rst, (j < hold) ? 1 : 0);
      end else begin
        chk("R5 pll_rst", pll_rst, 1);
        chk("R5 pll_range", pll_range, 0);
        chk("R5 pll_tune", pll_tune, 0);
        chk("R6 logic_rst", logic_rst, (j < hold) ? 1 : 0);
      end
      chk("R7 bus_block", bus_block, (j < hold) ? 1 : 0);
      // R2: pattern wiggles after capture must not reach the outputs
      init_mode  = 1'($urandom);
      init_range = RW'($urandom);
      @(negedge clk);
    end
  endtask

  task automatic finish_up();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    do_reset(3);
    run_seq(1'b0, 2, -1);
    do_reset(2);
    run_seq(1'b1, 3, -1);
    do_reset(1);
    run_seq(1'b1, 0, -1);
    do_reset(2);
    run_seq(1'b1, 1, 10);
    run_seq(1'b0, 1, 3);
    run_seq(1'b1, 2, LOCK + 1);
    run_seq(1'b1, 2, -1);
    for (int k = 0; k < 10; k++) begin
      bit m;
      int r;
      int ab;
      m  = 1'($urandom);
      r  = int'($urandom_range(TW - 1, 0));
      ab = ($urandom_range(3, 0) == 0) ? int'($urandom_range(exp_hold(m) + 1, 0)) : -1;
      do_reset(int'($urandom_range(3, 1)));
      run_seq(m, r, ab);
    end
    finish_up();
  end
endmodule